// File: doc/BRIEF.md
# Network Timing Reference Phase-Offset Encoder

The block tracks how an asynchronous 8 kHz timing reference drifts against a local timing grid derived from the sample clock. A free-running counter divides the sample clock modulo a run-time factor `c0_mod` and forms the local grid. Each rising edge of the reference is brought into the clock domain by a two-flop synchronizer and an edge detector. On that edge the counter value is latched into a current-phase register, and the older value moves to a previous-phase register. Once both registers hold measurements, the edge-to-edge phase change (current minus previous, taken modulo `c0_mod`) is summed, still modulo `c0_mod`, over each update window of `upd_len` sample clocks.

At the end of every window the summed change is mapped to a two's-complement count of sample clocks and offered on a valid/ready port. The word carries only the change seen inside its own window and no absolute phase. A far-end receiver that misses a word therefore loses only that window's correction, and no error builds up.

A small state machine gates the output while the history fills. It has three states. `ST_EMPTY` means no capture has been taken yet. `ST_ONE` means one capture is held. `ST_LOCK` means both history registers are real. The transitions are `ST_EMPTY -> ST_ONE` on the first synchronized edge and `ST_ONE -> ST_LOCK` on the second. `ST_LOCK` holds until reset.

Top module: `ntr_phase_encoder`

## Requirements
- R1: The local counter runs 0..`c0_mod`-1 and wraps to 0, and `ltr_mark` is high for one cycle in every `c0_mod` cycles, on the cycle the counter holds `c0_mod`-1.
- R2: After reset, `ofs_valid` stays low until two rising reference edges have been captured. With no edge, or with only one, no word is issued, however many windows pass.
- R3: In steady state, each word equals the total edge-to-edge phase change in its window. For a reference period of T sample clocks and a window of k·T, that total is (k·T) mod `c0_mod`, before the signed mapping of R4. A reference locked to the grid gives 0.
- R4: A modulo value u is mapped to u − `c0_mod` when u ≥ `c0_mod` − floor(`c0_mod`/2), and is kept as u otherwise. Every word therefore lies in −floor(`c0_mod`/2) .. `c0_mod`−1−floor(`c0_mod`/2). This holds for both odd and even `c0_mod`.
- R5: Once primed, the block issues exactly one word per `upd_len` sample clocks.
- R6: A presented word and `ofs_valid` stay unchanged until a cycle with `ofs_ready` high takes the word. After that cycle, `ofs_valid` is low unless a new word is issued in that same cycle.
- R7: If a new word is issued while the previous one is still untaken, the new word replaces it and `ofs_overrun` goes high. `ofs_overrun` then stays high until reset.
- R8: A replaced or untaken word has no effect on later words. Each later word still carries only its own window's change, not the sum of the windows that were not taken.
- R9: During and right after reset, `ofs_valid` = 0, `ofs_overrun` = 0 and `ofs_word` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ntr_ref_in | input | 1 | Asynchronous 8 kHz timing reference |
| c0_mod | input | CNT_W (14) | Division factor of the local grid |
| upd_len | input | PER_W (20) | Update window length in sample clocks |
| ltr_mark | output | 1 | One-cycle pulse at the end of each local grid period |
| ofs_word | output | CNT_W+1 (15) | Signed phase-offset word |
| ofs_valid | output | 1 | Offset word is presented |
| ofs_ready | input | 1 | Consumer takes the presented word |
| ofs_overrun | output | 1 | Sticky flag: an untaken word was replaced |

## Verification
The encoder is driven with periodic references at several periods. A period equal to the grid gives zero drift. Periods a few cycles longer and shorter give positive and negative drift, and these separate a sign error from a magnitude error. Periods whose accumulated change sits right at the mapping threshold, for both an even and an odd `c0_mod`, expose off-by-one faults in the modulo or signed mapping. A reference slower than the update window shows whether a single capture wrongly opens the output. Holding ready low through two windows separates a correct overwrite from an accumulating one.

// File: rtl/ntr_pkg.sv
package ntr_pkg;
    typedef enum logic [1:0] {
        ST_EMPTY = 2'd0,
        ST_ONE   = 2'd1,
        ST_LOCK  = 2'd2
    } prime_e;
endpackage

// File: rtl/ntr_edge_sync.sv
module ntr_edge_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise
);
    logic [2:0] sync_q;

    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[1:0], async_in};
    end

    assign rise = sync_q[1] & ~sync_q[2];
endmodule

// File: rtl/ntr_ltr_div.sv
module ntr_ltr_div #(
    parameter int CNT_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] c0,
    output logic [CNT_W-1:0] cnt,
    output logic             mark
);
    assign mark = (cnt >= c0 - 1'b1);

    always_ff @(posedge clk) begin
        if (!rst_n)    cnt <= '0;
        else if (mark) cnt <= '0;
        else           cnt <= cnt + 1'b1;
    end

    // R1: counter stays inside the modulus while it is held steady
    a_r1_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(c0) == c0 && c0 != '0 && $past(cnt) < c0) |-> cnt < c0);
endmodule

// File: rtl/ntr_phase_acc.sv
module ntr_phase_acc
    import ntr_pkg::*;
#(
    parameter int CNT_W  = 14,
    parameter int WORD_W = CNT_W + 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [CNT_W-1:0]         c0,
    input  logic [CNT_W-1:0]         cnt,
    input  logic                     rise,
    input  logic                     tick,
    output logic                     emit,
    output logic signed [WORD_W-1:0] word
);
    prime_e           state_q, state_d;
    logic [CNT_W-1:0] ph_cur, ph_prev, acc;
    logic [CNT_W-1:0] diff_u, sum_u;
    logic             pair_q;

    function automatic logic [CNT_W-1:0] mod_add(input logic [CNT_W-1:0] a,
                                                  input logic [CNT_W-1:0] b,
                                                  input logic [CNT_W-1:0] m);
        logic [CNT_W:0] s;
        s = {1'b0, a} + {1'b0, b};
        if (s >= {1'b0, m}) s = s - {1'b0, m};
        return s[CNT_W-1:0];
    endfunction

    function automatic logic [CNT_W-1:0] mod_sub(input logic [CNT_W-1:0] a,
                                                  input logic [CNT_W-1:0] b,
                                                  input logic [CNT_W-1:0] m);
        if (a >= b) return a - b;
        return a + (m - b);
    endfunction

    function automatic logic signed [WORD_W-1:0] to_signed(input logic [CNT_W-1:0] u,
                                                            input logic [CNT_W-1:0] m);
        logic [CNT_W-1:0] half;
        half = m >> 1;
        if (u >= m - half) return $signed({1'b0, u}) - $signed({1'b0, m});
        return $signed({1'b0, u});
    endfunction

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY: if (rise) state_d = ST_ONE;
            ST_ONE:   if (rise) state_d = ST_LOCK;
            ST_LOCK:  state_d = ST_LOCK;
            default:  state_d = ST_EMPTY;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_EMPTY;
        else        state_q <= state_d;
    end

    // capture history and window accumulator
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_cur  <= '0;
            ph_prev <= '0;
            pair_q  <= 1'b0;
            acc     <= '0;
        end else begin
            if (rise) begin
                ph_prev <= ph_cur;
                ph_cur  <= cnt;
            end
            pair_q <= rise && (state_q != ST_EMPTY);
            acc    <= tick ? '0 : sum_u;
        end
    end

    // outputs
    always_comb begin
        diff_u = pair_q ? mod_sub(ph_cur, ph_prev, c0) : '0;
        sum_u  = mod_add(acc, diff_u, c0);
        word   = to_signed(sum_u, c0);
        emit   = tick && (state_q == ST_LOCK);
    end

    // R4: every issued word lies in the signed range set by the modulus
    a_r4_word_range: assert property (@(posedge clk) disable iff (!rst_n)
        emit |-> (word >= -$signed({1'b0, c0 >> 1}))
              && (word <  $signed({1'b0, c0}) - $signed({1'b0, c0 >> 1})));
endmodule

// File: rtl/ntr_phase_encoder.sv
module ntr_phase_encoder #(
    parameter int CNT_W  = 14,
    parameter int PER_W  = 20,
    localparam int WORD_W = CNT_W + 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     ntr_ref_in,
    input  logic [CNT_W-1:0]         c0_mod,
    input  logic [PER_W-1:0]         upd_len,
    output logic                     ltr_mark,
    output logic signed [WORD_W-1:0] ofs_word,
    output logic                     ofs_valid,
    input  logic                     ofs_ready,
    output logic                     ofs_overrun
);
    logic                     rise, tick, emit;
    logic [CNT_W-1:0]         ltr_cnt;
    logic [PER_W-1:0]         pcnt;
    logic signed [WORD_W-1:0] word;

    ntr_edge_sync u_sync (
        .clk(clk), .rst_n(rst_n), .async_in(ntr_ref_in), .rise(rise)
    );

    ntr_ltr_div #(.CNT_W(CNT_W)) u_div (
        .clk(clk), .rst_n(rst_n), .c0(c0_mod), .cnt(ltr_cnt), .mark(ltr_mark)
    );

    ntr_phase_acc #(.CNT_W(CNT_W), .WORD_W(WORD_W)) u_acc (
        .clk(clk), .rst_n(rst_n), .c0(c0_mod), .cnt(ltr_cnt),
        .rise(rise), .tick(tick), .emit(emit), .word(word)
    );

    // update window timer
    assign tick = (pcnt >= upd_len - 1'b1);

    always_ff @(posedge clk) begin
        if (!rst_n)    pcnt <= '0;
        else if (tick) pcnt <= '0;
        else           pcnt <= pcnt + 1'b1;
    end

    // output holding register with overwrite
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ofs_word    <= '0;
            ofs_valid   <= 1'b0;
            ofs_overrun <= 1'b0;
        end else if (emit) begin
            ofs_word  <= word;
            ofs_valid <= 1'b1;
            if (ofs_valid && !ofs_ready) ofs_overrun <= 1'b1;
        end else if (ofs_valid && ofs_ready) begin
            ofs_valid <= 1'b0;
        end
    end

    // checker state: captured edges since reset, saturating at two
    logic [1:0] seen_q;
    always_ff @(posedge clk) begin
        if (!rst_n)                    seen_q <= '0;
        else if (rise && seen_q != 2'd2) seen_q <= seen_q + 1'b1;
    end

    // R2: no word before two captures
    a_r2_primed: assert property (@(posedge clk) disable iff (!rst_n)
        ofs_valid |-> seen_q == 2'd2);
    // R6: untaken word is held
    a_r6_hold_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (ofs_valid && !ofs_ready) |=> ofs_valid);
    a_r6_hold_word: assert property (@(posedge clk) disable iff (!rst_n)
        (ofs_valid && !ofs_ready && !tick) |=> $stable(ofs_word));
    // R7: overwrite raises the flag and the flag is sticky
    a_r7_overrun_set: assert property (@(posedge clk) disable iff (!rst_n)
        (ofs_valid && !ofs_ready && emit) |=> ofs_overrun);
    a_r7_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ofs_overrun |=> ofs_overrun);
endmodule

// File: tb/ntr_phase_encoder_tb.sv
module ntr_phase_encoder_tb;
    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               ref_sig = 1'b0;
    logic [13:0]        c0_mod = 14'd100;
    logic [19:0]        upd_len = 20'd400;
    logic               ltr_mark;
    logic signed [14:0] ofs_word;
    logic               ofs_valid;
    logic               ofs_ready = 1'b0;
    logic               ofs_overrun;

    int     vectors = 0;
    int     miscompares = 0;
    longint cyc = 0;
    bit     ref_en = 1'b0;
    int     ref_per = 100;

    ntr_phase_encoder u_dut (
        .clk(clk), .rst_n(rst_n), .ntr_ref_in(ref_sig), .c0_mod(c0_mod),
        .upd_len(upd_len), .ltr_mark(ltr_mark), .ofs_word(ofs_word),
        .ofs_valid(ofs_valid), .ofs_ready(ofs_ready), .ofs_overrun(ofs_overrun)
    );

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // reference generator, period ref_per cycles
    always begin
        if (ref_en) begin
            ref_sig = 1'b1;
            repeat (ref_per / 2) @(negedge clk);
            ref_sig = 1'b0;
            repeat (ref_per - ref_per / 2) @(negedge clk);
        end else begin
            ref_sig = 1'b0;
            @(negedge clk);
        end
    end

    task automatic chk(input string req, input longint act, input longint exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int exp_word(input int span, input int m);
        int u;
        u = span % m;
        return (u >= m - m / 2) ? u - m : u;
    endfunction

    task automatic do_reset(input int m, input int len);
        rst_n = 1'b0;
        ref_en = 1'b0;
        ofs_ready = 1'b0;
        c0_mod = 14'(m);
        upd_len = 20'(len);
        repeat (1100) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic get_word(output int w, output longint at);
        while (!ofs_valid) @(negedge clk);
        w = int'(ofs_word);
        at = cyc;
        ofs_ready = 1'b1;
        @(negedge clk);
        ofs_ready = 1'b0;
    endtask

    task automatic t_reset_and_grid();
        longint t0;
        do_reset(100, 400);
        chk("R9 valid", ofs_valid, 0);
        chk("R9 overrun", ofs_overrun, 0);
        chk("R9 word", ofs_word, 0);
        while (!ltr_mark) @(negedge clk);
        t0 = cyc;
        @(negedge clk);
        while (!ltr_mark) @(negedge clk);
        chk("R1 grid period c0=100", cyc - t0, 100);
        do_reset(37, 400);
        while (!ltr_mark) @(negedge clk);
        t0 = cyc;
        @(negedge clk);
        while (!ltr_mark) @(negedge clk);
        chk("R1 grid period c0=37", cyc - t0, 37);
    endtask

    task automatic t_priming();
        int seen;
        do_reset(100, 200);
        seen = 0;
        repeat (600) begin
            @(negedge clk);
            if (ofs_valid) seen++;
        end
        chk("R2 no edge no word", seen, 0);
        ref_per = 1000;
        ref_en = 1'b1;
        repeat (900) begin
            @(negedge clk);
            if (ofs_valid) seen++;
        end
        chk("R2 one capture no word", seen, 0);
        repeat (1300) begin
            @(negedge clk);
            if (ofs_valid) seen++;
        end
        chk("R2 word after two captures", seen > 0, 1);
    endtask

    task automatic t_steady(input int m, input int per, input int k, input string tag);
        int w;
        longint a0, a1;
        do_reset(m, per * k);
        ref_per = per;
        ref_en = 1'b1;
        get_word(w, a0);
        get_word(w, a0);
        chk({"R3 ", tag}, w, exp_word(per * k, m));
        get_word(w, a1);
        chk({"R4 ", tag}, w, exp_word(per * k, m));
        chk({"R5 spacing ", tag}, a1 - a0, per * k);
    endtask

    task automatic t_hold_and_overrun();
        int w;
        longint a;
        do_reset(100, 412);
        ref_per = 103;
        ref_en = 1'b1;
        get_word(w, a);
        while (!ofs_valid) @(negedge clk);
        w = int'(ofs_word);
        repeat (200) @(negedge clk);
        chk("R6 valid held", ofs_valid, 1);
        chk("R6 word held", ofs_word, w);
        chk("R7 no overrun yet", ofs_overrun, 0);
        repeat (300) @(negedge clk);
        chk("R7 overrun set", ofs_overrun, 1);
        chk("R8 replaced word single window", ofs_word, 12);
        ofs_ready = 1'b1;
        @(negedge clk);
        ofs_ready = 1'b0;
        chk("R6 valid drops after take", ofs_valid, 0);
        get_word(w, a);
        chk("R8 next word single window", w, 12);
        chk("R7 overrun sticky", ofs_overrun, 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        t_reset_and_grid();
        t_priming();
        t_steady(100, 100, 4, "locked");
        t_steady(100, 103, 4, "drift +12");
        t_steady(100, 97, 4, "drift -12");
        t_steady(100, 149, 1, "edge +49");
        t_steady(100, 150, 1, "edge -50");
        t_steady(100, 125, 2, "wrap -50");
        t_steady(37, 55, 1, "odd +18");
        t_steady(37, 56, 1, "odd -18");
        t_hold_and_overrun();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule